// File: doc/BRIEF.md
# Pattern-Table Bank Translator with Tile-Triggered Half Selection

This block sits between the picture processor's pattern-table address bus and the character ROM. It converts a 13-bit pattern address (0x0000 to 0x1FFF) into a wider ROM address. The conversion uses eight bank registers that the CPU loads, a page-size mode, and an outer-slice number that confines every mode to a fixed window of the ROM. The page size can be 8 KB, 4 KB, 2 KB or 1 KB.

In 4 KB mode each half of the pattern space chooses between two bank registers. The choice is made by a small latch. The latch flips when the picture processor fetches one of two marker tiles in that half, so the bank in use can change partway through a frame without any CPU involvement.

The translated address is registered and appears one clock after the pattern address is presented. Nametable mapping is handled elsewhere.

Top module: `chr_bank_xlate`

## Requirements
- R1: After synchronous reset, chr_addr is 0, every bank low and high register holds 0xFF, the mode is 8 KB (0), the outer slice is 0 and both half latches select the first register of their pair. The first translation of pattern address 0x0000 therefore gives 0x3E000.
- R2: A CPU write at 0x9000+n (n = 0..7) loads low byte n, and a write at 0xA000+n loads high byte n. A write at 0xD000 sets the mode from data bits [4:3]. A write at 0xD003 sets the outer slice to {data[4], data[3], data[0]}, and every other data bit is dropped. Writes to any other address, such as 0x9008, change nothing.
- R3: Mode 0 (8 KB): chr_addr = {outer[2:0], low0[4:0], pa[12:0]}.
- R4: Mode 1 (4 KB): chr_addr = {outer[2:0], lowR[5:0], pa[11:0]}. For pa[12]=0, R is register 0 or 2; for pa[12]=1, R is register 4 or 6. The choice follows the latch of that half.
- R5: Mode 2 (2 KB): chr_addr = {outer[2:0], lowR[6:0], pa[10:0]}, where R = {pa[12], pa[11], 0}.
- R6: Mode 3 (1 KB): chr_addr = {outer[2:0], lowR[7:0], pa[9:0]}, where R = pa[12:10].
- R7: The high-byte registers are stored, but in every mode they are masked out and never change chr_addr.
- R8: A cycle with ppu_fetch high and pa[11:4] = 0xFD sets the latch of half pa[12] to the first register. With pa[11:4] = 0xFE it sets that latch to the second register. Other tiles, and any cycle with ppu_fetch low, leave both latches unchanged.
- R9: chr_addr is registered. It shows the translation of the address presented before a clock edge, using the register and latch contents held before that edge. A bank write or latch update taking place at the same edge is seen only from the next translation onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-table address |
| ppu_fetch | input | 1 | Pattern fetch strobe, qualifies latch updates |
| chr_addr | output | 21 | Registered character ROM address |

## Verification
Two functions can act in the same cycle. The first is a translation that reads a bank register while the CPU writes that same register. The second is a translation of a marker-tile fetch that also flips the half latch it depends on. The bench provokes the first by asserting a low-byte write to register 0 in the cycle that pattern address 0x0000 is presented in 1 KB mode. It provokes the second by fetching tile 0xFE and then tile 0xFD in 4 KB mode. In both cases the output of that same cycle must carry the old bank, and the next translation must carry the new one.

// File: rtl/chr_xlate_pkg.sv
package chr_xlate_pkg;
  localparam int CPU_AW  = 16;
  localparam int DW      = 8;
  localparam int PPU_AW  = 13;
  localparam int NREG    = 8;
  localparam int IDX_W   = $clog2(NREG);
  localparam int OUTER_W = 3;
  localparam int CHR_AW  = 10 + DW + OUTER_W;

  typedef enum logic [1:0] {
    PAGE_8K = 2'd0,
    PAGE_4K = 2'd1,
    PAGE_2K = 2'd2,
    PAGE_1K = 2'd3
  } page_mode_e;
endpackage

// File: rtl/chr_reg_file.sv
module chr_reg_file
  import chr_xlate_pkg::*;
#(
  parameter logic [CPU_AW-1:0] LO_BASE    = 16'h9000,
  parameter logic [CPU_AW-1:0] HI_BASE    = 16'hA000,
  parameter logic [CPU_AW-1:0] MODE_ADDR  = 16'hD000,
  parameter logic [CPU_AW-1:0] OUTER_ADDR = 16'hD003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [2*DW-1:0]   rd_bank,
  output page_mode_e        mode_o,
  output logic [OUTER_W-1:0] outer_o
);
  logic [DW-1:0] lo_mem [NREG];
  logic [DW-1:0] hi_mem [NREG];
  page_mode_e    mode_q;
  logic [OUTER_W-1:0] outer_q;

  logic lo_hit, hi_hit, mode_hit, outer_hit;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    wr_idx    = wr_addr[IDX_W-1:0];
    lo_hit    = wr_en && (wr_addr[CPU_AW-1:IDX_W] == LO_BASE[CPU_AW-1:IDX_W]);
    hi_hit    = wr_en && (wr_addr[CPU_AW-1:IDX_W] == HI_BASE[CPU_AW-1:IDX_W]);
    mode_hit  = wr_en && (wr_addr == MODE_ADDR);
    outer_hit = wr_en && (wr_addr == OUTER_ADDR);
  end

  // Bank byte arrays: one write port, one asynchronous read port each.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        lo_mem[i] <= '1;
        hi_mem[i] <= '1;
      end
    end else begin
      if (lo_hit) lo_mem[wr_idx] <= wr_data;
      if (hi_hit) hi_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PAGE_8K;
      outer_q <= '0;
    end else begin
      if (mode_hit)  mode_q  <= page_mode_e'(wr_data[4:3]);
      if (outer_hit) outer_q <= {wr_data[4], wr_data[3], wr_data[0]};
    end
  end

  assign rd_bank = {hi_mem[rd_idx], lo_mem[rd_idx]};
  assign mode_o  = mode_q;
  assign outer_o = outer_q;

  assert_lo_write_R2: assert property (@(posedge clk) disable iff (rst)
    lo_hit |=> lo_mem[$past(wr_idx)] == $past(wr_data));

  assert_outer_pick_R2: assert property (@(posedge clk) disable iff (rst)
    outer_hit |=> outer_q == {$past(wr_data[4]), $past(wr_data[3]), $past(wr_data[0])});

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !mode_hit |=> $stable(mode_q));
endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch
  import chr_xlate_pkg::*;
#(
  parameter logic [7:0] TILE_FIRST  = 8'hFD,
  parameter logic [7:0] TILE_SECOND = 8'hFE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fetch,
  input  logic       half,
  input  logic [7:0] tile,
  output logic [1:0] sel_o
);
  logic [1:0] sel_q;
  logic hit_first, hit_second;

  assign hit_first  = fetch && (tile == TILE_FIRST);
  assign hit_second = fetch && (tile == TILE_SECOND);

  // One latch per pattern half, indexed by the half bit.
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)                                  sel_q[h] <= 1'b0;
      else if (hit_first  && (half == h[0]))    sel_q[h] <= 1'b0;
      else if (hit_second && (half == h[0]))    sel_q[h] <= 1'b1;
    end
  end

  assign sel_o = sel_q;

  assert_first_tile_R8: assert property (@(posedge clk) disable iff (rst)
    hit_first |=> sel_q[$past(half)] == 1'b0);

  assert_second_tile_R8: assert property (@(posedge clk) disable iff (rst)
    hit_second |=> sel_q[$past(half)] == 1'b1);

  assert_no_fetch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(sel_q));
endmodule

// File: rtl/chr_addr_gen.sv
module chr_addr_gen
  import chr_xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  page_mode_e         mode,
  input  logic [OUTER_W-1:0] outer,
  input  logic [1:0]         half_sel,
  input  logic [PPU_AW-1:0]  ppu_addr,
  input  logic [2*DW-1:0]    rd_bank,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [CHR_AW-1:0]  chr_addr
);
  localparam int OFS1K = 10;
  localparam int TOP1K = OFS1K + DW - 1;

  logic [CHR_AW-1:0] xlate;
  logic              pa_hi;
  logic [DW-1:0]     inner;
  logic              out_valid_q;

  assign pa_hi = ppu_addr[PPU_AW-1];
  assign inner = rd_bank[DW-1:0];

  always_comb begin
    unique case (mode)
      PAGE_8K: rd_idx = '0;
      PAGE_4K: rd_idx = {pa_hi, half_sel[pa_hi], 1'b0};
      PAGE_2K: rd_idx = {ppu_addr[12:11], 1'b0};
      default: rd_idx = ppu_addr[12:10];
    endcase
  end

  // Mode picks how many inner bank bits survive and where the outer slice lands.
  always_comb begin
    unique case (mode)
      PAGE_8K: xlate = {outer, inner[4:0], ppu_addr[12:0]};
      PAGE_4K: xlate = {outer, inner[5:0], ppu_addr[11:0]};
      PAGE_2K: xlate = {outer, inner[6:0], ppu_addr[10:0]};
      default: xlate = {outer, inner[7:0], ppu_addr[9:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr    <= '0;
      out_valid_q <= 1'b0;
    end else begin
      chr_addr    <= xlate;
      out_valid_q <= 1'b1;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> chr_addr == '0);

  assert_offset_pass_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |-> chr_addr[OFS1K-1:0] == $past(ppu_addr[OFS1K-1:0]));

  assert_outer_top_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |-> chr_addr[CHR_AW-1 -: OUTER_W] == $past(outer));

  assert_high_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid_q && $past(mode) == PAGE_1K) |->
      ({{DW{1'b0}}, chr_addr[TOP1K:OFS1K]} == ($past(rd_bank) & {{DW{1'b0}}, {DW{1'b1}}})));
endmodule

// File: rtl/chr_bank_xlate.sv
module chr_bank_xlate
  import chr_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wr_data,
  input  logic [12:0]       ppu_addr,
  input  logic              ppu_fetch,
  output logic [20:0]       chr_addr
);
  page_mode_e         mode;
  logic [OUTER_W-1:0] outer;
  logic [IDX_W-1:0]   rd_idx;
  logic [2*DW-1:0]    rd_bank;
  logic [1:0]         half_sel;

  chr_reg_file u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr_en),
    .wr_addr (cpu_addr),
    .wr_data (cpu_wr_data),
    .rd_idx  (rd_idx),
    .rd_bank (rd_bank),
    .mode_o  (mode),
    .outer_o (outer)
  );

  chr_tile_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .fetch (ppu_fetch),
    .half  (ppu_addr[12]),
    .tile  (ppu_addr[11:4]),
    .sel_o (half_sel)
  );

  chr_addr_gen u_gen (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .outer    (outer),
    .half_sel (half_sel),
    .ppu_addr (ppu_addr),
    .rd_bank  (rd_bank),
    .rd_idx   (rd_idx),
    .chr_addr (chr_addr)
  );
endmodule

// File: tb/tb_chr_bank_xlate.sv
module tb_chr_bank_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wr_data = '0;
  logic [12:0] ppu_addr = '0;
  logic        ppu_fetch = 1'b0;
  logic [20:0] chr_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  chr_bank_xlate dut (.*);

  // {mode write, outer write, pattern address, expected ROM address, requirement}
  typedef struct packed {
    logic [7:0]  mode_v;
    logic [7:0]  outer_v;
    logic [12:0] pa;
    logic [20:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 13'h0123, 21'h00A123, 4'd3},  // R3 8 KB, outer 0
    '{8'h00, 8'h19, 13'h1FFF, 21'h1CBFFF, 4'd3},  // R3 8 KB, outer 7
    '{8'h08, 8'h01, 13'h0456, 21'h065456, 4'd4},  // R4 4 KB lower half, reg0
    '{8'h08, 8'h08, 13'h1ABC, 21'h08FABC, 4'd4},  // R4 4 KB upper half, reg4
    '{8'h10, 8'h10, 13'h0ABC, 21'h12D2BC, 4'd5},  // R5 2 KB slot 1 -> reg2
    '{8'h10, 8'h00, 13'h1FFF, 21'h03DFFF, 4'd5},  // R5 2 KB slot 3 -> reg6
    '{8'h18, 8'h19, 13'h142A, 21'h1F842A, 4'd6},  // R6 1 KB slot 5
    '{8'h18, 8'h00, 13'h0000, 21'h029400, 4'd6},  // R6 1 KB slot 0
    '{8'h18, 8'h02, 13'h0C05, 21'h025805, 4'd2}   // R2 outer data bit 1 dropped
  };

  localparam logic [7:0] LOW_INIT [8] = '{8'hA5, 8'h3C, 8'h5A, 8'h96, 8'h0F, 8'hE1, 8'h7B, 8'hC3};

  task automatic check(input string tag, input logic [20:0] got, input logic [20:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: chr_addr=%h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wr_data = d; cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic present(input logic [12:0] a, input logic f);
    ppu_addr = a; ppu_fetch = f;
    @(negedge clk);
    ppu_fetch = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 output held at zero in reset", chr_addr, 21'h0);
    rst = 1'b0;
    present(13'h0000, 1'b0);
    check("R1 reset banks 0xFF, 8 KB mode", chr_addr, 21'h03E000);

    for (int i = 0; i < 8; i++) begin
      cpu_write(16'h9000 + 16'(i), LOW_INIT[i]);
      cpu_write(16'hA000 + 16'(i), 8'h80 + 8'(i));
    end

    for (int v = 0; v < NV; v++) begin
      cpu_write(16'hD000, VECS[v].mode_v);
      cpu_write(16'hD003, VECS[v].outer_v);
      present(VECS[v].pa, 1'b0);
      check($sformatf("R%0d vector %0d", VECS[v].req, v), chr_addr, VECS[v].exp);
    end

    // Latch behaviour in 4 KB mode, outer 0
    cpu_write(16'hD000, 8'h08);
    cpu_write(16'hD003, 8'h00);
    present(13'h0FE8, 1'b1);
    check("R9 marker fetch translated with old latch", chr_addr, 21'h025FE8);
    present(13'h0100, 1'b0);
    check("R8 tile FE selects reg2 in lower half", chr_addr, 21'h01A100);
    present(13'h1100, 1'b0);
    check("R8 upper half untouched", chr_addr, 21'h00F100);
    present(13'h1FE0, 1'b1);
    check("R9 upper marker fetch uses old latch", chr_addr, 21'h00FFE0);
    present(13'h1100, 1'b0);
    check("R8 tile FE selects reg6 in upper half", chr_addr, 21'h03B100);
    present(13'h0FD0, 1'b0);
    present(13'h0100, 1'b0);
    check("R8 FD without strobe ignored", chr_addr, 21'h01A100);
    present(13'h0FC0, 1'b1);
    present(13'h0100, 1'b0);
    check("R8 other tile ignored", chr_addr, 21'h01A100);
    present(13'h1FD5, 1'b1);
    present(13'h1100, 1'b0);
    check("R8 tile FD restores reg4", chr_addr, 21'h00F100);
    present(13'h0100, 1'b0);
    check("R8 lower half kept by upper FD", chr_addr, 21'h01A100);

    // Same-cycle write and translation in 1 KB mode
    cpu_write(16'hD000, 8'h18);
    ppu_addr = 13'h0000;
    cpu_write(16'h9000, 8'h11);
    check("R9 write in same cycle not yet visible", chr_addr, 21'h029400);
    @(negedge clk);
    check("R9 write visible next cycle", chr_addr, 21'h004400);
    cpu_write(16'h9008, 8'h00);
    present(13'h0000, 1'b0);
    check("R2 out-of-range write ignored", chr_addr, 21'h004400);
    cpu_write(16'hA003, 8'h55);
    present(13'h0C05, 1'b0);
    check("R7 high byte has no effect", chr_addr, 21'h025805);

    finish_run();
  end
endmodule